// File: doc/BRIEF.md
# Reset Source Capture Controller

This block sits in the always-powered part of a chip. It issues the chip-wide reset and keeps a record of why that reset happened. Five origins can start a reset: power-on, watchdog expiry, wake from the deepest sleep state, a software request, and an over-temperature sensor. Software starts its own reset by writing a trigger bit through a small word-addressed register port. That write is never acknowledged, because the port stops accepting traffic as soon as the reset begins.

When one or more origins are active in the same cycle, the block encodes the winner into a 3-bit cause field and holds it. It then drives a reset pulse that lasts at least a parameterised number of cycles. The pulse is stretched for as long as a level request stays high. Scratch words survive every reset except power-on, so firmware can leave a value (for example 2, meaning "enter recovery boot") before it triggers a software reset and read that value back afterwards. The cause field can also be loaded by software, so any 3-bit value can be stored and read back. A flag marks whether the stored value is one of the five defined codes.

The pulse sequencer is a three-state machine:
- IDLE: no reset is active and the port is ready.
- ASSERT: the minimum-length counter is running.
- HOLD: the minimum has elapsed, but a level request is still high.

Its transitions are:
- IDLE→ASSERT on any request.
- ASSERT→ASSERT while the count runs.
- ASSERT→IDLE when the count ends and no request is high.
- ASSERT→HOLD when the count ends and a request is still high.
- HOLD→HOLD while a request stays high.
- HOLD→IDLE once every request is low.
- Any state→ASSERT (count restarted) while power-on is high.

Top module: `rsc_ctrl`

## Requirements
- R1: While `por_req` is high, `chip_rst` is 1 and `reg_ready` is 0, and the cause field and every scratch word are cleared to 0. After `por_req` falls, `chip_rst` stays high for exactly PULSE_MIN more cycles.
- R2: A write in IDLE to offset 0 with data bit 0 set makes `chip_rst` rise at the next clock edge and drops `reg_ready`. The same write with bit 0 clear has no effect.
- R3: The cause field occupies status bits [4:2] at offset 1. Its codes are 0 power-on, 1 watchdog, 2 wake, 3 software and 4 thermal. Status bits [31:5] and bit 1 read 0.
- R4: When several origins are active in the same IDLE cycle, the recorded cause follows the order power-on, then thermal, then watchdog, then software, then wake.
- R5: A request lasting a single cycle gives a `chip_rst` pulse of exactly PULSE_MIN cycles (default 16).
- R6: If a level request is still high when the minimum ends, `chip_rst` stays high and falls at the first edge that samples all requests low.
- R7: Scratch words (offset 2 + i, DATA_W bits each) keep their contents across watchdog, wake, software and thermal resets.
- R8: Status bit 0 reads 1 exactly when the cause field holds 0 to 4. A write to offset 1 loads bits [4:2] of the data into the field, so the values 5 to 7 can be stored and read back with bit 0 at 0.
- R9: While `chip_rst` is high, register writes and non-power-on requests change neither the cause field nor the scratch words.
- R10: `reg_ready` is 1 in IDLE and 0 in ASSERT and HOLD.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on clock |
| por_req | input | 1 | Power-on request, active high; also resets this block |
| wdog_req | input | 1 | Watchdog expiry request, level |
| wake_req | input | 1 | Deep-sleep wake request, level |
| therm_req | input | 1 | Over-temperature request, level |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Word offset: 0 trigger, 1 status, 2+ scratch |
| reg_wdata | input | DATA_W | Write data |
| reg_rdata | output | DATA_W | Read data, combinational from `reg_addr` |
| reg_ready | output | 1 | Port accepts writes (IDLE only) |
| chip_rst | output | 1 | Chip-wide reset pulse, active high |

## Verification
Two functions can fall in the same cycle. First, a software trigger write can land together with hardware requests, so that software reset and the priority encoder act at once. Second, a register write or a fresh request can arrive while a pulse is already running, so that the write path and the cause latch act at once. The vector table provokes the first case by issuing the trigger write in the same IDLE cycle as combinations of thermal, watchdog and wake requests. Each combination is judged by the recorded status code and the pulse length. A directed run covers the second case: it holds the watchdog request past the minimum and injects a thermal request and a scratch write mid-pulse, then checks that the cause, the scratch word and the stretched length are as required.

// File: rtl/rsc_pkg.sv
package rsc_pkg;

    typedef enum logic [2:0] {
        CAUSE_POR    = 3'd0,
        CAUSE_WDOG   = 3'd1,
        CAUSE_WAKE   = 3'd2,
        CAUSE_SWMAIN = 3'd3,
        CAUSE_THERM  = 3'd4
    } cause_e;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_ASSERT = 2'd1,
        ST_HOLD   = 2'd2
    } pstate_e;

    // Priority ranks: lower rank wins
    localparam int unsigned RANK_POR   = 0;
    localparam int unsigned RANK_THERM = 1;
    localparam int unsigned RANK_WDOG  = 2;
    localparam int unsigned RANK_SW    = 3;
    localparam int unsigned RANK_WAKE  = 4;
    localparam int unsigned NUM_SRC    = 5;

    // Register offsets and status layout
    localparam int unsigned OFF_CTRL     = 0;
    localparam int unsigned OFF_STATUS   = 1;
    localparam int unsigned OFF_SCRATCH0 = 2;
    localparam int unsigned FIELD_LSB    = 2;
    localparam int unsigned FIELD_W      = 3;
    localparam int unsigned KNOWN_BIT    = 0;
    localparam logic [2:0]  CODE_MAX     = 3'd4;

    function automatic logic [2:0] rank_code(input int unsigned rank);
        logic [2:0] c;
        case (rank)
            RANK_POR:   c = CAUSE_POR;
            RANK_THERM: c = CAUSE_THERM;
            RANK_WDOG:  c = CAUSE_WDOG;
            RANK_SW:    c = CAUSE_SWMAIN;
            RANK_WAKE:  c = CAUSE_WAKE;
            default:    c = CAUSE_POR;
        endcase
        return c;
    endfunction

endpackage

// File: rtl/rsc_prio.sv
module rsc_prio
    import rsc_pkg::*;
(
    input  logic [NUM_SRC-1:0] req_vec,
    output logic               any_req,
    output logic [2:0]         win_code
);

    logic [NUM_SRC:0]   seen;
    logic [NUM_SRC-1:0] hit;

    assign seen[0] = 1'b0;

    for (genvar g = 0; g < NUM_SRC; g++) begin : g_rank
        assign hit[g]    = req_vec[g] & ~seen[g];
        assign seen[g+1] = seen[g] | req_vec[g];
    end

    assign any_req = seen[NUM_SRC];

    always_comb begin
        win_code = '0;
        for (int unsigned i = 0; i < NUM_SRC; i++) begin
            if (hit[i]) begin
                win_code = win_code | rank_code(i);
            end
        end
    end

endmodule

// File: rtl/rsc_pulse_fsm.sv
module rsc_pulse_fsm
    import rsc_pkg::*;
#(
    parameter int unsigned PULSE_MIN = 16
) (
    input  logic clk,
    input  logic por,
    input  logic start,
    input  logic hold_req,
    output logic rst_out,
    output logic idle
);

    localparam int unsigned CNT_W = (PULSE_MIN > 2) ? $clog2(PULSE_MIN) : 1;
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(PULSE_MIN - 1);

    pstate_e          state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;

    // State register
    always_ff @(posedge clk) begin
        if (por) begin
            state_q <= ST_ASSERT;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    // Next state
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        unique case (state_q)
            ST_IDLE: begin
                cnt_d = '0;
                if (start) begin
                    state_d = ST_ASSERT;
                end
            end
            ST_ASSERT: begin
                if (cnt_q == CNT_LAST) begin
                    cnt_d   = '0;
                    state_d = hold_req ? ST_HOLD : ST_IDLE;
                end else begin
                    cnt_d = cnt_q + 1'b1;
                end
            end
            ST_HOLD: begin
                if (!hold_req) begin
                    state_d = ST_IDLE;
                end
            end
            default: begin
                state_d = ST_IDLE;
                cnt_d   = '0;
            end
        endcase
    end

    // Outputs
    always_comb begin
        rst_out = (state_q != ST_IDLE);
        idle    = (state_q == ST_IDLE);
    end

endmodule

// File: rtl/rsc_regs.sv
module rsc_regs
    import rsc_pkg::*;
#(
    parameter int unsigned DATA_W      = 32,
    parameter int unsigned ADDR_W      = 3,
    parameter int unsigned NUM_SCRATCH = 2
) (
    input  logic                          clk,
    input  logic                          por,
    input  logic                          wr_en,
    input  logic [ADDR_W-1:0]             addr,
    input  logic [DATA_W-1:0]             wdata,
    input  logic                          capture,
    input  logic [2:0]                    cap_code,
    output logic [DATA_W-1:0]             rdata,
    output logic [2:0]                    cause_q,
    output logic [NUM_SCRATCH*DATA_W-1:0] scratch_flat
);

    localparam logic [ADDR_W-1:0] A_STATUS = ADDR_W'(OFF_STATUS);

    logic [DATA_W-1:0] scratch_q [NUM_SCRATCH];
    logic              field_known;

    // Cause field: power-on beats capture beats software load
    always_ff @(posedge clk) begin
        if (por) begin
            cause_q <= CAUSE_POR;
        end else if (capture) begin
            cause_q <= cap_code;
        end else if (wr_en && addr == A_STATUS) begin
            cause_q <= wdata[FIELD_LSB +: FIELD_W];
        end
    end

    for (genvar s = 0; s < NUM_SCRATCH; s++) begin : g_scr
        localparam logic [ADDR_W-1:0] A_SCR = ADDR_W'(OFF_SCRATCH0 + s);

        always_ff @(posedge clk) begin
            if (por) begin
                scratch_q[s] <= '0;
            end else if (wr_en && addr == A_SCR) begin
                scratch_q[s] <= wdata;
            end
        end

        assign scratch_flat[s*DATA_W +: DATA_W] = scratch_q[s];
    end

    assign field_known = (cause_q <= CODE_MAX);

    always_comb begin
        rdata = '0;
        if (addr == A_STATUS) begin
            rdata[FIELD_LSB +: FIELD_W] = cause_q;
            rdata[KNOWN_BIT]            = field_known;
        end
        for (int unsigned i = 0; i < NUM_SCRATCH; i++) begin
            if (addr == ADDR_W'(OFF_SCRATCH0 + i)) begin
                rdata = scratch_q[i];
            end
        end
    end

endmodule

// File: rtl/rsc_ctrl.sv
module rsc_ctrl
    import rsc_pkg::*;
#(
    parameter int unsigned DATA_W      = 32,
    parameter int unsigned ADDR_W      = 3,
    parameter int unsigned NUM_SCRATCH = 2,
    parameter int unsigned PULSE_MIN   = 16
) (
    input  logic              clk,
    input  logic              por_req,
    input  logic              wdog_req,
    input  logic              wake_req,
    input  logic              therm_req,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    output logic              reg_ready,
    output logic              chip_rst
);

    localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(OFF_CTRL);

    logic               idle;
    logic               acc_wr;
    logic               sw_fire;
    logic [NUM_SRC-1:0] req_vec;
    logic               any_req;
    logic [2:0]         win_code;
    logic               capture;
    logic               hold_req;
    logic [2:0]         cause_q;
    logic [NUM_SCRATCH*DATA_W-1:0] scratch_flat;

    assign acc_wr  = reg_wr & idle;
    assign sw_fire = acc_wr & (reg_addr == A_CTRL) & reg_wdata[0];

    always_comb begin
        req_vec             = '0;
        req_vec[RANK_POR]   = por_req;
        req_vec[RANK_THERM] = therm_req;
        req_vec[RANK_WDOG]  = wdog_req;
        req_vec[RANK_SW]    = sw_fire;
        req_vec[RANK_WAKE]  = wake_req;
    end

    assign hold_req = therm_req | wdog_req | wake_req;
    assign capture  = idle & any_req & ~por_req;

    rsc_prio u_prio (
        .req_vec  (req_vec),
        .any_req  (any_req),
        .win_code (win_code)
    );

    rsc_pulse_fsm #(.PULSE_MIN(PULSE_MIN)) u_fsm (
        .clk      (clk),
        .por      (por_req),
        .start    (any_req),
        .hold_req (hold_req),
        .rst_out  (chip_rst),
        .idle     (idle)
    );

    rsc_regs #(
        .DATA_W      (DATA_W),
        .ADDR_W      (ADDR_W),
        .NUM_SCRATCH (NUM_SCRATCH)
    ) u_regs (
        .clk          (clk),
        .por          (por_req),
        .wr_en        (acc_wr),
        .addr         (reg_addr),
        .wdata        (reg_wdata),
        .capture      (capture),
        .cap_code     (win_code),
        .rdata        (reg_rdata),
        .cause_q      (cause_q),
        .scratch_flat (scratch_flat)
    );

    assign reg_ready = idle;

endmodule

// File: rtl/rsc_ctrl_chk.sv
module rsc_ctrl_chk #(
    parameter int unsigned DATA_W      = 32,
    parameter int unsigned ADDR_W      = 3,
    parameter int unsigned NUM_SCRATCH = 2,
    parameter int unsigned PULSE_MIN   = 16
) (
    input logic                          clk,
    input logic                          por_req,
    input logic                          therm_req,
    input logic                          reg_wr,
    input logic [ADDR_W-1:0]             reg_addr,
    input logic                          trig_bit,
    input logic [4:0]                    rd_low,
    input logic                          reg_ready,
    input logic                          chip_rst,
    input logic [2:0]                    cause_q,
    input logic [NUM_SCRATCH*DATA_W-1:0] scratch_flat
);

    localparam int unsigned HC_W = $clog2(PULSE_MIN + 1) + 1;

    logic [HC_W-1:0] hi_cnt;

    always_ff @(posedge clk) begin
        if (por_req) begin
            hi_cnt <= '0;
        end else if (chip_rst) begin
            if (hi_cnt < HC_W'(PULSE_MIN)) begin
                hi_cnt <= hi_cnt + 1'b1;
            end
        end else begin
            hi_cnt <= '0;
        end
    end

    AST_POR_EXIT: assert property (@(posedge clk) disable iff (por_req)
        $fell(por_req) |-> (chip_rst && cause_q == 3'd0 && scratch_flat == '0)); // R1

    AST_SW_TRIGGER: assert property (@(posedge clk) disable iff (por_req)
        (reg_ready && reg_wr && reg_addr == ADDR_W'(0) && trig_bit) |=> (chip_rst && !reg_ready)); // R2

    AST_THERM_FIRST: assert property (@(posedge clk) disable iff (por_req)
        (reg_ready && therm_req) |=> (cause_q == 3'd4)); // R4

    AST_MIN_PULSE: assert property (@(posedge clk) disable iff (por_req)
        $fell(chip_rst) |-> (hi_cnt >= HC_W'(PULSE_MIN))); // R5

    AST_KNOWN_FLAG: assert property (@(posedge clk) disable iff (por_req)
        (reg_addr == ADDR_W'(1)) |-> (rd_low[0] == (rd_low[4:2] <= 3'd4))); // R8

    AST_CAUSE_HELD: assert property (@(posedge clk) disable iff (por_req)
        (chip_rst && $past(chip_rst)) |-> $stable(cause_q)); // R9

    AST_SCRATCH_FROZEN: assert property (@(posedge clk) disable iff (por_req)
        (!reg_ready) |=> $stable(scratch_flat)); // R9

    AST_READY_MATCH: assert property (@(posedge clk) disable iff (por_req)
        reg_ready != chip_rst); // R10

endmodule

bind rsc_ctrl rsc_ctrl_chk #(
    .DATA_W      (DATA_W),
    .ADDR_W      (ADDR_W),
    .NUM_SCRATCH (NUM_SCRATCH),
    .PULSE_MIN   (PULSE_MIN)
) chk_i (
    .clk          (clk),
    .por_req      (por_req),
    .therm_req    (therm_req),
    .reg_wr       (reg_wr),
    .reg_addr     (reg_addr),
    .trig_bit     (reg_wdata[0]),
    .rd_low       (reg_rdata[4:0]),
    .reg_ready    (reg_ready),
    .chip_rst     (chip_rst),
    .cause_q      (cause_q),
    .scratch_flat (scratch_flat)
);

// File: tb/rsc_ctrl_tb_top.sv
module rsc_ctrl_tb_top;

    localparam int unsigned DW = 32;
    localparam int unsigned AW = 3;
    localparam int unsigned PMIN = 16;

    logic          clk = 1'b0;
    logic          por_req = 1'b1;
    logic          wdog_req = 1'b0;
    logic          wake_req = 1'b0;
    logic          therm_req = 1'b0;
    logic          reg_wr = 1'b0;
    logic [AW-1:0] reg_addr = '0;
    logic [DW-1:0] reg_wdata = '0;
    logic [DW-1:0] reg_rdata;
    logic          reg_ready;
    logic          chip_rst;

    int errs = 0;
    int checks = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    rsc_ctrl #(.DATA_W(DW), .ADDR_W(AW), .NUM_SCRATCH(2), .PULSE_MIN(PMIN)) dut_i (
        .clk       (clk),
        .por_req   (por_req),
        .wdog_req  (wdog_req),
        .wake_req  (wake_req),
        .therm_req (therm_req),
        .reg_wr    (reg_wr),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .reg_ready (reg_ready),
        .chip_rst  (chip_rst)
    );

    // mask [6:3] = {therm, wdog, sw, wake}, [2:0] = expected cause code
    localparam logic [6:0] VEC [8] = '{
        {4'b0100, 3'd1},
        {4'b0001, 3'd2},
        {4'b0010, 3'd3},
        {4'b1000, 3'd4},
        {4'b0101, 3'd1},
        {4'b0011, 3'd3},
        {4'b1111, 3'd4},
        {4'b0110, 3'd1}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errs++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic rd(input logic [AW-1:0] a, output logic [DW-1:0] v);
        reg_addr = a;
        #1;
        v = reg_rdata;
    endtask

    task automatic wr(input logic [AW-1:0] a, input logic [DW-1:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0; reg_wdata = '0;
    endtask

    task automatic count_pulse(output int n);
        n = 0;
        while (chip_rst && n < 1000) begin
            n++;
            @(negedge clk);
        end
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        if (!done) begin
            errs++;
            checks++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", errs, checks);
            $finish;
        end
    end

    initial begin : stim
        logic [DW-1:0] v;
        int n;

        // Reset state
        repeat (3) @(negedge clk);
        chk("R1 rst during por", {31'd0, chip_rst}, 32'd1);
        chk("R1 ready during por", {31'd0, reg_ready}, 32'd0);
        por_req = 1'b0;
        count_pulse(n);
        chk("R1 pulse after por", n, PMIN);
        rd(3'd1, v);
        chk("R1 status after por", v, 32'h1);
        rd(3'd2, v);
        chk("R1 scratch0 after por", v, 32'h0);
        chk("R10 ready in idle", {31'd0, reg_ready}, 32'd1);

        wr(3'd2, 32'd2);
        wr(3'd3, 32'hA5A5_0F0F);
        rd(3'd2, v);
        chk("R7 scratch0 written", v, 32'd2);

        // Trigger with bit 0 clear does nothing
        wr(3'd0, 32'hFFFF_FFFE);
        chk("R2 ctrl write of 0", {31'd0, chip_rst}, 32'd0);

        // Vector table: same-cycle combinations
        for (int i = 0; i < 8; i++) begin
            @(negedge clk);
            therm_req = VEC[i][6];
            wdog_req  = VEC[i][5];
            wake_req  = VEC[i][3];
            if (VEC[i][4]) begin
                reg_wr = 1'b1; reg_addr = 3'd0; reg_wdata = 32'd1;
            end
            @(negedge clk);
            therm_req = 1'b0; wdog_req = 1'b0; wake_req = 1'b0;
            reg_wr = 1'b0; reg_wdata = '0;
            chk("R2 R10 ready low in pulse", {31'd0, reg_ready}, 32'd0);
            count_pulse(n);
            chk("R5 pulse length", n, PMIN);
            rd(3'd1, v);
            chk("R3 R4 status code", v, {27'd0, VEC[i][2:0], 2'b01});
            rd(3'd2, v);
            chk("R7 scratch0 kept", v, 32'd2);
        end

        // Held watchdog with mid-pulse traffic
        @(negedge clk);
        wdog_req = 1'b1;
        n = 0;
        for (int k = 1; k <= 40; k++) begin
            @(negedge clk);
            if (chip_rst) n++;
            if (k == 10) therm_req = 1'b1;
            if (k == 11) therm_req = 1'b0;
            if (k == 12) begin
                chk("R10 ready low while held", {31'd0, reg_ready}, 32'd0);
                reg_wr = 1'b1; reg_addr = 3'd3; reg_wdata = 32'hDEAD_BEEF;
            end
            if (k == 13) begin
                reg_wr = 1'b1; reg_addr = 3'd1; reg_wdata = 32'h1C;
            end
            if (k == 14) begin
                reg_wr = 1'b0; reg_wdata = '0;
            end
            if (k == 30) wdog_req = 1'b0;
        end
        chk("R6 stretched pulse", n, 30);
        rd(3'd1, v);
        chk("R9 cause unchanged", v, 32'h5);
        rd(3'd3, v);
        chk("R9 scratch write ignored", v, 32'hA5A5_0F0F);

        // Unknown codes
        wr(3'd1, 32'h1C);
        rd(3'd1, v);
        chk("R8 code 7 unknown", v, 32'h1C);
        wr(3'd1, 32'h14);
        rd(3'd1, v);
        chk("R8 code 5 unknown", v, 32'h14);
        wr(3'd1, 32'hFFFF_FF10);
        rd(3'd1, v);
        chk("R8 R3 code 4 known", v, 32'h11);

        // Power-on with thermal in the same cycle
        @(negedge clk);
        por_req = 1'b1; therm_req = 1'b1;
        @(negedge clk);
        therm_req = 1'b0;
        repeat (3) @(negedge clk);
        por_req = 1'b0;
        count_pulse(n);
        chk("R1 pulse after second por", n, PMIN);
        rd(3'd1, v);
        chk("R1 R4 por beats thermal", v, 32'h1);
        rd(3'd2, v);
        chk("R1 scratch0 cleared", v, 32'h0);
        rd(3'd3, v);
        chk("R1 scratch1 cleared", v, 32'h0);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

endmodule